// File: doc/BRIEF.md
# UART Channel-Mode FIFO Router

This block holds the byte-wide receive and transmit FIFOs of a UART and steers every character among three parties: the CPU data register, the serial receiver and the serial transmitter. A two-bit channel mode in the control register picks the path. In normal mode CPU writes feed the transmitter and received bytes feed the CPU. In echo mode received bytes go to both FIFOs. Local loopback turns CPU writes back into the receive FIFO. Remote loopback sends received bytes straight back out.

Each direction has an enable bit and a disable bit, and it runs only when the enable bit is set and the disable bit is clear. Two control bits clear the FIFOs and do not stay set. A CPU write that finds its target FIFO full is dropped and flagged with a one-cycle overrun pulse. The bit-level serializer and deserializer sit outside the block. The receiver appears as a valid/ready byte stream into the block, and the transmitter as a valid/ready byte stream out of it. Both FIFO fill levels are exported for a status block.

Top module: `uart_chmode_router`

## Requirements
- R1: After reset the control register reads 0x128, both FIFO counts are 0, the read data is 0 and overrun is low. This leaves the mode at echo and both directions disabled.
- R2: The mode is control bits 9:8, with 00 normal, 01 echo, 10 local loopback and 11 remote loopback. A CPU data write goes to the TX FIFO in normal mode and to the RX FIFO in local loopback. It is discarded in echo and in remote loopback.
- R3: A byte accepted from the receiver is pushed into the RX FIFO in normal and echo modes, and into the TX FIFO in echo and remote loopback modes. In local loopback it is accepted and discarded.
- R4: RX is active only when control bit 2 is 1 and bit 3 is 0. TX is active only when bit 4 is 1 and bit 5 is 0. A push into an inactive direction is dropped. A data read while RX is inactive returns 0 and removes nothing.
- R5: Writing 1 to control bit 0 empties the RX FIFO, and writing 1 to bit 1 empties the TX FIFO. This takes effect at that same edge and overrides any push in that cycle. Both bits always read back 0. Only bits 2 to 5, 8 and 9 are stored, and every other bit reads 0.
- R6: A CPU write whose target FIFO already holds the full depth is dropped, and overrun is high for exactly the following cycle.
- R7: A data read with the RX FIFO empty returns 0 and leaves the count at 0.
- R8: rx_in_ready is low when the FIFO that the current mode would fill is full. In echo mode that means either FIFO. In local loopback rx_in_ready is always high.
- R9: Each FIFO delivers bytes in arrival order. Its count equals pushes minus pops and never exceeds the depth. The full test uses the count from before any pop in the same cycle.
- R10: tx_out_valid is high whenever the TX FIFO is not empty, and tx_out_data is its oldest byte. A byte leaves the FIFO when valid and ready are both high, whatever the TX enable bits say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 10 | Control write value |
| ctrl_rdata | output | 10 | Control register contents |
| dat_wr | input | 1 | CPU data register write strobe |
| dat_wdata | input | DATA_W | CPU write byte |
| dat_rd | input | 1 | CPU data register read strobe |
| dat_rdata | output | DATA_W | Byte returned by the last read |
| rx_in_valid | input | 1 | Receiver byte valid |
| rx_in_data | input | DATA_W | Receiver byte |
| rx_in_ready | output | 1 | Block can take a receiver byte |
| tx_out_valid | output | 1 | Transmit byte available |
| tx_out_data | output | DATA_W | Oldest transmit byte |
| tx_out_ready | input | 1 | Transmitter takes the byte |
| rx_count | output | $clog2(FIFO_DEPTH)+1 | RX FIFO fill level |
| tx_count | output | $clog2(FIFO_DEPTH)+1 | TX FIFO fill level |
| overrun | output | 1 | One-cycle dropped-write pulse |

## Verification
A stimulus applied in a cycle shows up in the counts, dat_rdata, overrun, ctrl_rdata and the transmit stream one rising edge later. rx_in_ready is combinational from the registered fill levels and the control register. It is therefore valid in the same cycle as the state it reflects. The bench drives inputs at the falling edge and advances its queue-based model by one step per cycle. It samples every output at the next falling edge, so each result is compared in exactly the cycle it is due.

// File: rtl/uart_rtr_pkg.sv
package uart_rtr_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_ECHO   = 2'b01,
        MODE_LOCAL  = 2'b10,
        MODE_REMOTE = 2'b11
    } chan_mode_e;

    localparam int CTRL_W = 10;
    localparam int B_RXCLR = 0;
    localparam int B_TXCLR = 1;
    localparam int B_RXEN  = 2;
    localparam int B_RXOFF = 3;
    localparam int B_TXEN  = 4;
    localparam int B_TXOFF = 5;
    localparam int B_MODE  = 8;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 10'h128;
    localparam logic [CTRL_W-1:0] CTRL_KEEP  = 10'h33C;

    typedef struct packed {
        chan_mode_e mode;
        logic       rx_on;
        logic       tx_on;
    } route_cfg_t;

endpackage

// File: rtl/uart_rtr_fifo.sv
module uart_rtr_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     push,
    input  logic [W-1:0]             din,
    input  logic                     pop,
    output logic [W-1:0]             head,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     full,
    output logic                     empty
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
    } fst_t;

    fst_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.wp = '0;
            st_d.rp = '0;
        end else begin
            if (push) st_d.wp = st_q.wp + 1'b1;
            if (pop)  st_d.rp = st_q.rp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem_q[st_q.wp[AW-1:0]] <= din;
    end

    assign count = st_q.wp - st_q.rp;
    assign full  = (count == (AW+1)'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem_q[st_q.rp[AW-1:0]];

    // R9: level stays within the depth
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));
    // R9: the router never pushes into a full buffer nor pops an empty one
    a_r9_push_room: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r9_pop_data: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R5: a clear empties the buffer at the next edge
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
endmodule

// File: rtl/uart_rtr_ctrl.sv
module uart_rtr_ctrl
    import uart_rtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata,
    output route_cfg_t        cfg,
    output logic              rx_clr,
    output logic              tx_clr
);
    logic [CTRL_W-1:0] ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) ctrl_d = wdata & CTRL_KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= CTRL_RESET;
        else        ctrl_q <= ctrl_d;
    end

    assign rdata     = ctrl_q;
    assign cfg.mode  = chan_mode_e'(ctrl_q[B_MODE+1:B_MODE]);
    assign cfg.rx_on = ctrl_q[B_RXEN] && !ctrl_q[B_RXOFF];
    assign cfg.tx_on = ctrl_q[B_TXEN] && !ctrl_q[B_TXOFF];
    assign rx_clr    = wr && wdata[B_RXCLR];
    assign tx_clr    = wr && wdata[B_TXCLR];
endmodule

// File: rtl/uart_rtr_route.sv
module uart_rtr_route
    import uart_rtr_pkg::*;
(
    input  route_cfg_t cfg,
    input  logic       cpu_wr,
    input  logic       rcv_valid,
    input  logic       rx_full,
    input  logic       tx_full,
    output logic       rcv_ready,
    output logic       rx_push,
    output logic       rx_from_cpu,
    output logic       tx_push,
    output logic       tx_from_cpu,
    output logic       ovr_hit
);
    logic cpu_to_rx, cpu_to_tx, rcv_take, rcv_to_rx, rcv_to_tx;

    always_comb begin
        unique case (cfg.mode)
            MODE_NORMAL: rcv_ready = !rx_full;
            MODE_ECHO:   rcv_ready = !rx_full && !tx_full;
            MODE_LOCAL:  rcv_ready = 1'b1;
            default:     rcv_ready = !tx_full;
        endcase
        cpu_to_rx = cpu_wr && (cfg.mode == MODE_LOCAL)  && cfg.rx_on;
        cpu_to_tx = cpu_wr && (cfg.mode == MODE_NORMAL) && cfg.tx_on;
        rcv_take  = rcv_valid && rcv_ready;
        rcv_to_rx = rcv_take && cfg.rx_on &&
                    (cfg.mode == MODE_NORMAL || cfg.mode == MODE_ECHO);
        rcv_to_tx = rcv_take && cfg.tx_on &&
                    (cfg.mode == MODE_ECHO || cfg.mode == MODE_REMOTE);
        rx_from_cpu = cpu_to_rx;
        tx_from_cpu = cpu_to_tx;
        rx_push   = (cpu_to_rx && !rx_full) || rcv_to_rx;
        tx_push   = (cpu_to_tx && !tx_full) || rcv_to_tx;
        ovr_hit   = (cpu_to_rx && rx_full) || (cpu_to_tx && tx_full);
    end
endmodule

// File: rtl/uart_chmode_router.sv
module uart_chmode_router
    import uart_rtr_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int DATA_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ctrl_wr,
    input  logic [9:0]                    ctrl_wdata,
    output logic [9:0]                    ctrl_rdata,
    input  logic                          dat_wr,
    input  logic [DATA_W-1:0]             dat_wdata,
    input  logic                          dat_rd,
    output logic [DATA_W-1:0]             dat_rdata,
    input  logic                          rx_in_valid,
    input  logic [DATA_W-1:0]             rx_in_data,
    output logic                          rx_in_ready,
    output logic                          tx_out_valid,
    output logic [DATA_W-1:0]             tx_out_data,
    input  logic                          tx_out_ready,
    output logic [$clog2(FIFO_DEPTH):0]   rx_count,
    output logic [$clog2(FIFO_DEPTH):0]   tx_count,
    output logic                          overrun
);
    localparam int CW   = $clog2(FIFO_DEPTH) + 1;
    localparam int NF   = 2;
    localparam int F_RX = 0;
    localparam int F_TX = 1;

    route_cfg_t cfg;
    logic       rx_clr, tx_clr;
    logic       rx_push, rx_from_cpu, tx_push, tx_from_cpu, ovr_hit;

    logic              f_clr   [NF];
    logic              f_push  [NF];
    logic              f_pop   [NF];
    logic [DATA_W-1:0] f_din   [NF];
    logic [DATA_W-1:0] f_head  [NF];
    logic [CW-1:0]     f_cnt   [NF];
    logic              f_full  [NF];
    logic              f_empty [NF];

    uart_rtr_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ctrl_wr),
        .wdata  (ctrl_wdata),
        .rdata  (ctrl_rdata),
        .cfg    (cfg),
        .rx_clr (rx_clr),
        .tx_clr (tx_clr)
    );

    uart_rtr_route u_route (
        .cfg         (cfg),
        .cpu_wr      (dat_wr),
        .rcv_valid   (rx_in_valid),
        .rx_full     (f_full[F_RX]),
        .tx_full     (f_full[F_TX]),
        .rcv_ready   (rx_in_ready),
        .rx_push     (rx_push),
        .rx_from_cpu (rx_from_cpu),
        .tx_push     (tx_push),
        .tx_from_cpu (tx_from_cpu),
        .ovr_hit     (ovr_hit)
    );

    logic rd_pop;
    assign rd_pop = dat_rd && cfg.rx_on && !f_empty[F_RX];

    assign f_clr[F_RX]  = rx_clr;
    assign f_push[F_RX] = rx_push;
    assign f_pop[F_RX]  = rd_pop;
    assign f_din[F_RX]  = rx_from_cpu ? dat_wdata : rx_in_data;
    assign f_clr[F_TX]  = tx_clr;
    assign f_push[F_TX] = tx_push;
    assign f_pop[F_TX]  = tx_out_ready && !f_empty[F_TX];
    assign f_din[F_TX]  = tx_from_cpu ? dat_wdata : rx_in_data;

    for (genvar g = 0; g < NF; g++) begin : g_fifo
        uart_rtr_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (f_clr[g]),
            .push  (f_push[g]),
            .din   (f_din[g]),
            .pop   (f_pop[g]),
            .head  (f_head[g]),
            .count (f_cnt[g]),
            .full  (f_full[g]),
            .empty (f_empty[g])
        );
    end

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              ovr;
    } rd_st_t;

    rd_st_t rs_d, rs_q;

    always_comb begin
        rs_d     = rs_q;
        rs_d.ovr = ovr_hit;
        if (dat_rd) rs_d.rdata = rd_pop ? f_head[F_RX] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign dat_rdata    = rs_q.rdata;
    assign overrun      = rs_q.ovr;
    assign rx_count     = f_cnt[F_RX];
    assign tx_count     = f_cnt[F_TX];
    assign tx_out_valid = !f_empty[F_TX];
    assign tx_out_data  = f_head[F_TX];

    // R6: an overrun pulse follows a CPU data write
    a_r6_ovr_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(dat_wr));
    // R7: reading an empty RX FIFO yields zero
    a_r7_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        dat_rd && rx_count == '0 |=> dat_rdata == '0);
    // R8: in normal mode ready implies free RX space
    a_r8_ready_room: assert property (@(posedge clk) disable iff (!rst_n)
        rx_in_ready && cfg.mode == MODE_NORMAL |-> rx_count < CW'(FIFO_DEPTH));
    // R3: in local loopback the receiver cannot change the RX level
    a_r3_local_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.mode == MODE_LOCAL && !dat_wr && !dat_rd && !ctrl_wr
        |=> rx_count == $past(rx_count));
    // R10: a stalled transmit byte stays put
    a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_valid && !tx_out_ready && !ctrl_wr
        |=> tx_out_valid && tx_out_data == $past(tx_out_data));
endmodule

// File: tb/uart_chmode_router_bench.sv
`timescale 1ns/1ps
module uart_chmode_router_bench;
    localparam int D  = 16;
    localparam int CW = $clog2(D) + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       b_cwr = 1'b0;
    logic [9:0] b_cdata = '0;
    logic       b_wr = 1'b0;
    logic [7:0] b_wdata = '0;
    logic       b_rd = 1'b0;
    logic       b_rxv = 1'b0;
    logic [7:0] b_rxd = '0;
    logic       b_txrdy = 1'b0;
    logic [9:0] o_ctrl;
    logic [7:0] o_rdata, o_txd;
    logic       o_ready, o_txv, o_ovr;
    logic [CW-1:0] o_rxn, o_txn;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    byte unsigned rxq[$];
    byte unsigned txq[$];
    logic [9:0] m_ctrl;
    logic [7:0] m_rdata;
    bit         m_ovr;

    always #10 clk = ~clk;

    uart_chmode_router #(.FIFO_DEPTH(D), .DATA_W(8)) u_uart_chmode_router (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(b_cwr), .ctrl_wdata(b_cdata), .ctrl_rdata(o_ctrl),
        .dat_wr(b_wr), .dat_wdata(b_wdata), .dat_rd(b_rd), .dat_rdata(o_rdata),
        .rx_in_valid(b_rxv), .rx_in_data(b_rxd), .rx_in_ready(o_ready),
        .tx_out_valid(o_txv), .tx_out_data(o_txd), .tx_out_ready(b_txrdy),
        .rx_count(o_rxn), .tx_count(o_txn), .overrun(o_ovr)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_ready();
        case (m_ctrl[9:8])
            2'b00:   return rxq.size() < D;
            2'b01:   return rxq.size() < D && txq.size() < D;
            2'b10:   return 1'b1;
            default: return txq.size() < D;
        endcase
    endfunction

    task automatic model_step();
        bit rx_on = m_ctrl[2] && !m_ctrl[3];
        bit tx_on = m_ctrl[4] && !m_ctrl[5];
        logic [1:0] md = m_ctrl[9:8];
        int rxn = rxq.size();
        int txn = txq.size();
        bit take = b_rxv && exp_ready();
        m_ovr = 0;
        if (b_rd) begin
            if (rx_on && rxn > 0) m_rdata = rxq.pop_front();
            else                  m_rdata = 8'h00;
        end
        if (b_txrdy && txn > 0) void'(txq.pop_front());
        if (b_wr) begin
            if (md == 2'b00 && tx_on) begin
                if (txn == D) m_ovr = 1; else txq.push_back(b_wdata);
            end else if (md == 2'b10 && rx_on) begin
                if (rxn == D) m_ovr = 1; else rxq.push_back(b_wdata);
            end
        end
        if (take) begin
            if ((md == 2'b00 || md == 2'b01) && rx_on) rxq.push_back(b_rxd);
            if ((md == 2'b01 || md == 2'b11) && tx_on) txq.push_back(b_rxd);
        end
        if (b_cwr) begin
            m_ctrl = b_cdata & 10'h33C;
            if (b_cdata[0]) rxq.delete();
            if (b_cdata[1]) txq.delete();
        end
    endtask

    task automatic cmp_all();
        chk("R9", "rx_count", int'(o_rxn), rxq.size());
        chk("R9", "tx_count", int'(o_txn), txq.size());
        chk("R5", "ctrl_rdata", int'(o_ctrl), int'(m_ctrl));
        chk("R7", "dat_rdata", int'(o_rdata), int'(m_rdata));
        chk("R6", "overrun", int'(o_ovr), int'(m_ovr));
        chk("R8", "rx_in_ready", int'(o_ready), int'(exp_ready()));
        chk("R10", "tx_out_valid", int'(o_txv), int'(txq.size() > 0));
        if (txq.size() > 0) chk("R10", "tx_out_data", int'(o_txd), int'(txq[0]));
    endtask

    task automatic idle();
        b_cwr = 0; b_wr = 0; b_rd = 0; b_rxv = 0; b_txrdy = 0;
    endtask

    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        cmp_all();
        idle();
    endtask

    task automatic set_ctrl(logic [9:0] v);
        b_cwr = 1; b_cdata = v; step();
    endtask

    task automatic cpu_write(logic [7:0] v);
        b_wr = 1; b_wdata = v; step();
    endtask

    task automatic rcv_byte(logic [7:0] v);
        b_rxv = 1; b_rxd = v; step();
    endtask

    task automatic cpu_read();
        b_rd = 1; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        m_ctrl = 10'h128; m_rdata = 8'h00; m_ovr = 0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        chk("R1", "ctrl reset", int'(o_ctrl), 'h128);
        chk("R1", "rx_count reset", int'(o_rxn), 0);
        chk("R1", "overrun reset", int'(o_ovr), 0);
        cmp_all();

        // R4: both directions disabled after reset, echo byte dropped
        rcv_byte(8'hA5);
        chk("R4", "rx dropped while off", int'(o_rxn), 0);
        chk("R4", "tx dropped while off", int'(o_txn), 0);

        // R2: local loopback, CPU writes fill RX
        set_ctrl(10'h214);
        for (int i = 0; i < D; i++) cpu_write(8'(i + 8'h30));
        chk("R2", "local fill", int'(o_rxn), D);
        chk("R8", "ready in local when full", int'(o_ready), 1);
        // R6: one more write overruns
        cpu_write(8'hEE);
        chk("R6", "overrun pulse", int'(o_ovr), 1);
        chk("R6", "level kept", int'(o_rxn), D);
        step();
        chk("R6", "pulse one cycle", int'(o_ovr), 0);
        // R3: receiver byte ignored in local loopback
        rcv_byte(8'h77);
        chk("R3", "local discards receiver", int'(o_rxn), D);
        // R9: drain in order
        for (int i = 0; i < D; i++) begin
            cpu_read();
            chk("R9", "order", int'(o_rdata), i + 'h30);
        end
        // R7: empty read
        cpu_read();
        chk("R7", "empty read zero", int'(o_rdata), 0);
        chk("R7", "count stays 0", int'(o_rxn), 0);

        // R2: normal mode, CPU writes to TX
        set_ctrl(10'h014);
        cpu_write(8'h11); cpu_write(8'h22);
        chk("R2", "normal to tx", int'(o_txn), 2);
        chk("R10", "tx head", int'(o_txd), 'h11);
        // R5: TX reset self clears
        set_ctrl(10'h016);
        chk("R5", "tx cleared", int'(o_txn), 0);
        chk("R5", "clear bit reads 0", int'(o_ctrl), 'h014);
        // R4: disable wins over enable
        set_ctrl(10'h03C);
        cpu_write(8'h55);
        chk("R4", "tx disable wins", int'(o_txn), 0);
        b_rd = 1; step();
        chk("R4", "read while rx off", int'(o_rdata), 0);

        // R3: echo fills both; R2: CPU write dropped in echo
        set_ctrl(10'h114);
        rcv_byte(8'h9C);
        chk("R3", "echo rx", int'(o_rxn), 1);
        chk("R3", "echo tx", int'(o_txn), 1);
        cpu_write(8'h01);
        chk("R2", "echo drops cpu", int'(o_txn), 1);
        // R3: remote loopback fills only TX
        set_ctrl(10'h317);
        rcv_byte(8'h3D);
        chk("R3", "remote rx untouched", int'(o_rxn), 0);
        chk("R3", "remote tx", int'(o_txn), 1);
        // R8: ready drops when TX full in remote
        for (int i = 0; i < D; i++) rcv_byte(8'(i));
        chk("R8", "remote full not ready", int'(o_ready), 0);
        // R10: transmitter drains even with TX disabled
        set_ctrl(10'h324);
        b_txrdy = 1; step();
        chk("R10", "drain while off", int'(o_txn), D - 1);

        // random phase
        for (int c = 0; c < 6000; c++) begin
            b_wr    = ($urandom % 3) == 0;
            b_wdata = 8'($urandom);
            b_rd    = ($urandom % 3) == 0;
            b_rxv   = ($urandom % 2) == 0;
            b_rxd   = 8'($urandom);
            b_txrdy = ($urandom % 4) != 0;
            if (($urandom % 40) == 0) begin
                b_cwr   = 1;
                b_cdata = '0;
                b_cdata[9:8] = 2'($urandom);
                b_cdata[2] = ($urandom % 5) != 0;
                b_cdata[3] = ($urandom % 6) == 0;
                b_cdata[4] = ($urandom % 5) != 0;
                b_cdata[5] = ($urandom % 6) == 0;
                b_cdata[0] = ($urandom % 8) == 0;
                b_cdata[1] = ($urandom % 8) == 0;
                b_cdata[7:6] = 2'($urandom);
            end
            step();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule